// File: doc/BRIEF.md
# Short I2C Transaction Offload Sequencer

This block sits in front of an I2C byte engine and runs a whole short transaction from a single control-register write. The transaction is a write, a read, or a write and then a read. Each direction carries 1 to 8 bytes. Outgoing bytes are taken from a pair of 32-bit transmit words, and incoming bytes are packed into a pair of 32-bit receive words. Byte 0 is the least significant byte of the low word. The sequencer issues one command at a time to the byte engine and waits for that command's completion before it issues the next.

Between the write phase and the read phase the block either issues a repeated start or closes the bus with a stop and then opens it again, as the control word selects. It handles 7-bit and 10-bit target addresses. A missing acknowledge on an address byte or a data byte ends the run early with a stop and sets the error flag. When the final stop completes, the block sets the completion cause bit. The interrupt line is that bit gated by a mask bit. Software clears the cause by writing zero to it.

Top module: `i2c_txn_offload`

## Requirements
- R1: After reset every readable register reads 0, `irq` is low and `eng_valid` is low.
- R2: Register index 0 is the control word: bit 0 write phase, bit 1 read phase, bits [11:2] target address, bit 12 10-bit addressing, bits [15:13] transmit count minus one, bits [18:16] receive count minus one, bit 19 run, bit 20 repeated start. A write to it while idle, with bit 19 set and bit 0 or bit 1 set, starts a run. The first command of a run is START (code 1).
- R3: An address is sent with WRITE (code 3). With a 7-bit address the sequencer sends the single byte {addr[6:0], rw}. With a 10-bit address it sends {5'b11110, addr[9:8], rw} and then addr[7:0]. After a repeated start only the first of these bytes is sent. rw is 0 in the write phase and 1 in the read phase.
- R4: The write phase sends the transmit count of data bytes with WRITE. Data byte k is bits [8k+7:8k] of {tx_hi (index 6), tx_lo (index 5)}.
- R5: The read phase issues READ_ACK (code 4) for every byte except the last, and READ_NACK (code 5) for the last byte. Byte k is stored at bits [8k+7:8k] of {rx_hi (index 8), rx_lo (index 7)}. Both receive words are cleared when a run starts.
- R6: When both phases are selected, the write phase comes first. Bit 20 set gives RESTART (code 2) between the phases. Bit 20 clear gives STOP (code 6) and then START, followed by the full read address.
- R7: A NACK on any address byte or write data byte is followed at once by STOP. No further byte is sent, and the status word (index 1) bit 0 reads 1 after the run.
- R8: Every run ends with STOP. When the STOP completes, cause (index 2) bit 0 becomes 1, the block returns to idle, and `irq` equals cause bit 0 AND mask (index 3) bit 0.
- R9: Writing 0 to the cause register clears it and drops `irq`. The timing word (index 4) is writable and appears on `eng_pace`. Writing 0 to the timing word, to the mask or to the control word resets it to 0.
- R10: A control write while a run is in progress is ignored. The running transaction and the stored control word stay unchanged. A control write with bit 19 set but neither phase bit set issues no command and sets no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| irq | output | 1 | Cause AND mask |
| eng_valid | output | 1 | One-cycle command strobe to the byte engine |
| eng_cmd | output | 3 | Command code: 1 START, 2 RESTART, 3 WRITE, 4 READ_ACK, 5 READ_NACK, 6 STOP |
| eng_byte | output | 8 | Byte to transmit with WRITE |
| eng_pace | output | 32 | Timing word passed to the bus driver |
| eng_done | input | 1 | Byte engine finished the last command |
| eng_ack | input | 1 | Target acknowledged (meaningful for WRITE) |
| eng_rx | input | 8 | Received byte (meaningful for reads) |

## Verification
A register write takes effect at the next clock edge. The first command strobe appears on the cycle after the run-starting write. Each later command is strobed on the cycle after the edge that samples the previous `eng_done`. The cause bit rises on the edge that samples the final STOP's `eng_done`, and reads are combinational. The bench's byte-engine model therefore logs each strobe at the falling edge and raises `eng_done` two falling edges later for exactly one cycle. The bench waits for completion by polling the cause register rather than counting cycles. It then compares the whole command log, the receive words, the error flag and `irq` against values it builds from the control word.

// File: rtl/i2c_off_pkg.sv
package i2c_off_pkg;
  localparam int MAXB  = 8;
  localparam int BUF_W = MAXB * 8;
  localparam int IDX_W = $clog2(MAXB);

  // register indices
  localparam int RI_CTRL  = 0;
  localparam int RI_STAT  = 1;
  localparam int RI_CAUSE = 2;
  localparam int RI_MASK  = 3;
  localparam int RI_PACE  = 4;
  localparam int RI_TXLO  = 5;
  localparam int RI_TXHI  = 6;
  localparam int RI_RXLO  = 7;
  localparam int RI_RXHI  = 8;

  // control word bit positions
  localparam int CB_WR   = 0;
  localparam int CB_RD   = 1;
  localparam int CB_ADR  = 2;
  localparam int CB_EXT  = 12;
  localparam int CB_TXL  = 13;
  localparam int CB_RXL  = 16;
  localparam int CB_RUN  = 19;
  localparam int CB_REP  = 20;

  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_RD_ACK  = 3'd4,
    CMD_RD_NACK = 3'd5,
    CMD_STOP    = 3'd6
  } bus_cmd_e;

  typedef struct packed {
    logic             wr;
    logic             rd;
    logic [9:0]       addr;
    logic             ext;
    logic [IDX_W-1:0] txm1;
    logic [IDX_W-1:0] rxm1;
    logic             rep;
  } job_t;

  // first address byte; hi2 = addr[9:8], lo7 = addr[6:0]
  function automatic logic [7:0] head_byte(input logic [1:0] hi2,
                                           input logic [6:0] lo7,
                                           input logic ext, input logic rd);
    return ext ? {5'b11110, hi2, rd} : {lo7, rd};
  endfunction

  // byte idx of a little-endian packed buffer
  function automatic logic [7:0] pick_byte(input logic [BUF_W-1:0] d,
                                           input logic [IDX_W-1:0] idx);
    return d[{idx, 3'b000} +: 8];
  endfunction
endpackage

// File: rtl/i2c_off_regs.sv
module i2c_off_regs
  import i2c_off_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              busy,
  input  logic              done,
  output logic [31:0]       ctrl_q,
  output logic [BUF_W-1:0]  tx_q,
  output logic [31:0]       pace_q,
  output logic              mask_q,
  output logic              cause_q,
  output logic              launch,
  output job_t              job
);
  logic hit_ctrl, hit_cause, hit_mask, hit_pace, hit_txlo, hit_txhi;

  assign hit_ctrl  = we && (addr == REG_AW'(RI_CTRL));
  assign hit_cause = we && (addr == REG_AW'(RI_CAUSE));
  assign hit_mask  = we && (addr == REG_AW'(RI_MASK));
  assign hit_pace  = we && (addr == REG_AW'(RI_PACE));
  assign hit_txlo  = we && (addr == REG_AW'(RI_TXLO));
  assign hit_txhi  = we && (addr == REG_AW'(RI_TXHI));

  assign job = '{wr:   wdata[CB_WR],
                 rd:   wdata[CB_RD],
                 addr: wdata[CB_ADR +: 10],
                 ext:  wdata[CB_EXT],
                 txm1: wdata[CB_TXL +: IDX_W],
                 rxm1: wdata[CB_RXL +: IDX_W],
                 rep:  wdata[CB_REP]};

  assign launch = hit_ctrl && !busy && wdata[CB_RUN] && (wdata[CB_WR] || wdata[CB_RD]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tx_q    <= '0;
      pace_q  <= '0;
      mask_q  <= 1'b0;
      cause_q <= 1'b0;
    end else begin
      if (hit_ctrl && !busy) ctrl_q <= wdata;
      if (hit_txlo)  tx_q[31:0]  <= wdata;
      if (hit_txhi)  tx_q[63:32] <= wdata;
      if (hit_pace)  pace_q <= wdata;
      if (hit_mask)  mask_q <= wdata[0];
      if (hit_cause) cause_q <= wdata[0];
      if (done)      cause_q <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_off_seq.sv
module i2c_off_seq
  import i2c_off_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  job_t             job,
  input  logic [BUF_W-1:0] tx_data,
  output logic             eng_valid,
  output bus_cmd_e         eng_cmd,
  output logic [7:0]       eng_byte,
  input  logic             eng_done,
  input  logic             eng_ack,
  input  logic [7:0]       eng_rx,
  output logic             busy,
  output logic             done,
  output logic             nack_seen,
  output logic             err,
  output logic [BUF_W-1:0] rx_data
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADR1, ST_ADR2, ST_WR,
    ST_MIDSTOP, ST_RESTART, ST_RD, ST_STOP
  } st_e;

  st_e              st;
  logic             waiting, rd_phase, after_rs;
  logic [IDX_W-1:0] idx;
  job_t             jq;
  logic [BUF_W-1:0] txq;
  logic             step, nackable, last_wr, last_rd;

  assign busy      = (st != ST_IDLE);
  assign eng_valid = busy && !waiting;
  assign step      = waiting && eng_done;
  assign nackable  = (st == ST_ADR1) || (st == ST_ADR2) || (st == ST_WR);
  assign nack_seen = step && nackable && !eng_ack;
  assign done      = step && (st == ST_STOP);
  assign last_wr   = (idx == jq.txm1);
  assign last_rd   = (idx == jq.rxm1);

  always_comb begin
    eng_cmd  = CMD_NONE;
    eng_byte = 8'h00;
    case (st)
      ST_START:   eng_cmd = CMD_START;
      ST_ADR1: begin
        eng_cmd  = CMD_WRITE;
        eng_byte = head_byte(jq.addr[9:8], jq.addr[6:0], jq.ext, rd_phase);
      end
      ST_ADR2: begin
        eng_cmd  = CMD_WRITE;
        eng_byte = jq.addr[7:0];
      end
      ST_WR: begin
        eng_cmd  = CMD_WRITE;
        eng_byte = pick_byte(txq, idx);
      end
      ST_MIDSTOP: eng_cmd = CMD_STOP;
      ST_RESTART: eng_cmd = CMD_RESTART;
      ST_RD:      eng_cmd = last_rd ? CMD_RD_NACK : CMD_RD_ACK;
      ST_STOP:    eng_cmd = CMD_STOP;
      default:    eng_cmd = CMD_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      waiting  <= 1'b0;
      rd_phase <= 1'b0;
      after_rs <= 1'b0;
      idx      <= '0;
      jq       <= '0;
      txq      <= '0;
      err      <= 1'b0;
      rx_data  <= '0;
    end else if (launch) begin
      jq       <= job;
      txq      <= tx_data;
      rx_data  <= '0;
      err      <= 1'b0;
      idx      <= '0;
      after_rs <= 1'b0;
      rd_phase <= !job.wr;
      waiting  <= 1'b0;
      st       <= ST_START;
    end else begin
      if (eng_valid) waiting <= 1'b1;
      if (step) begin
        waiting <= 1'b0;
        case (st)
          ST_START: st <= ST_ADR1;
          ST_ADR1: begin
            if (!eng_ack) begin
              err <= 1'b1;
              st  <= ST_STOP;
            end else if (jq.ext && !after_rs) st <= ST_ADR2;
            else st <= rd_phase ? ST_RD : ST_WR;
          end
          ST_ADR2: begin
            if (!eng_ack) begin
              err <= 1'b1;
              st  <= ST_STOP;
            end else st <= rd_phase ? ST_RD : ST_WR;
          end
          ST_WR: begin
            if (!eng_ack) begin
              err <= 1'b1;
              st  <= ST_STOP;
            end else if (last_wr) begin
              idx <= '0;
              if (jq.rd) st <= jq.rep ? ST_RESTART : ST_MIDSTOP;
              else       st <= ST_STOP;
            end else idx <= idx + 1'b1;
          end
          ST_MIDSTOP: begin
            rd_phase <= 1'b1;
            st       <= ST_START;
          end
          ST_RESTART: begin
            rd_phase <= 1'b1;
            after_rs <= 1'b1;
            st       <= ST_ADR1;
          end
          ST_RD: begin
            rx_data[{idx, 3'b000} +: 8] <= eng_rx;
            if (last_rd) st <= ST_STOP;
            else idx <= idx + 1'b1;
          end
          ST_STOP: st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_txn_offload.sv
module i2c_txn_offload
  import i2c_off_pkg::*;
#(
  parameter int REG_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              eng_valid,
  output logic [2:0]        eng_cmd,
  output logic [7:0]        eng_byte,
  output logic [31:0]       eng_pace,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [7:0]        eng_rx
);
  logic [31:0]      ctrl_q;
  logic [BUF_W-1:0] tx_q, rx_q;
  logic             mask_q, cause_q, launch, busy, done, nack_seen, seq_err;
  job_t             job;
  bus_cmd_e         cmd_e;

  i2c_off_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .done(done), .ctrl_q(ctrl_q), .tx_q(tx_q), .pace_q(eng_pace),
    .mask_q(mask_q), .cause_q(cause_q), .launch(launch), .job(job)
  );

  i2c_off_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .job(job), .tx_data(tx_q),
    .eng_valid(eng_valid), .eng_cmd(cmd_e), .eng_byte(eng_byte),
    .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx),
    .busy(busy), .done(done), .nack_seen(nack_seen), .err(seq_err),
    .rx_data(rx_q)
  );

  assign eng_cmd = cmd_e;
  assign irq     = cause_q & mask_q;

  always_comb begin
    case (int'(reg_addr))
      RI_CTRL:  reg_rdata = ctrl_q;
      RI_STAT:  reg_rdata = {31'd0, seq_err};
      RI_CAUSE: reg_rdata = {31'd0, cause_q};
      RI_MASK:  reg_rdata = {31'd0, mask_q};
      RI_PACE:  reg_rdata = eng_pace;
      RI_TXLO:  reg_rdata = tx_q[31:0];
      RI_TXHI:  reg_rdata = tx_q[63:32];
      RI_RXLO:  reg_rdata = rx_q[31:0];
      RI_RXHI:  reg_rdata = rx_q[63:32];
      default:  reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/i2c_txn_offload_chk.sv
module i2c_txn_offload_chk #(
  parameter int REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              busy,
  input logic              launch,
  input logic              eng_valid,
  input logic [2:0]        eng_cmd,
  input logic              nack_seen,
  input logic              seq_err,
  input logic              done,
  input logic              cause_q,
  input logic [31:0]       ctrl_q
);
  // R1: no command strobe outside a run
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_valid);

  // R2: a start request enters the running state
  a_r2_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);

  // R4: each command is strobed for exactly one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |=> !eng_valid);

  // R7: a missing acknowledge raises the error flag
  a_r7_nack_err: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> seq_err);

  // R7: the next command after a missing acknowledge is STOP
  a_r7_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    nack_seen |=> (eng_valid && eng_cmd == 3'd6));

  // R8: completion sets the cause bit and ends the run
  a_r8_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cause_q && !busy));

  // R10: control writes during a run leave the stored word alone
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == '0) |=> $stable(ctrl_q));
endmodule

bind i2c_txn_offload i2c_txn_offload_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy), .launch(launch), .eng_valid(eng_valid), .eng_cmd(eng_cmd),
  .nack_seen(nack_seen), .seq_err(seq_err), .done(done),
  .cause_q(cause_q), .ctrl_q(ctrl_q)
);

// File: tb/i2c_txn_offload_test.sv
`timescale 1ns/1ps
module i2c_txn_offload_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, eng_valid;
  logic [2:0]  eng_cmd;
  logic [7:0]  eng_byte;
  logic [31:0] eng_pace;
  logic        eng_done = 1'b0;
  logic        eng_ack = 1'b1;
  logic [7:0]  eng_rx = '0;

  i2c_txn_offload uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .eng_valid(eng_valid), .eng_cmd(eng_cmd), .eng_byte(eng_byte),
    .eng_pace(eng_pace), .eng_done(eng_done), .eng_ack(eng_ack), .eng_rx(eng_rx)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // byte-engine model state and log
  int         n_log = 0;
  int         log_cmd [64];
  logic [7:0] log_byte[64];
  int         nack_at = -1;
  int         rd_cnt = 0;
  logic [7:0] rx_seed = 8'h00;
  int         cnt = 0;
  int         cur_idx = 0;
  int         cur_cmd = 0;

  // expected list
  int         exp_n;
  int         exp_cmd [64];
  logic [7:0] exp_byte[64];
  bit         exp_nk  [64];
  string      exp_tag [64];
  bit         exp_err;
  logic       mask_now = 1'b0;

  function automatic logic [7:0] rx_pat(input logic [7:0] seed, input int k);
    return seed ^ 8'(k * 29 + 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // engine responder
  initial begin
    forever begin
      @(negedge clk);
      if (eng_done) eng_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done = 1'b1;
          eng_ack  = (cur_idx != nack_at);
          if (cur_cmd == 4 || cur_cmd == 5) begin
            eng_rx = rx_pat(rx_seed, rd_cnt);
            rd_cnt++;
          end
        end
      end
      if (eng_valid) begin
        if (n_log < 64) begin
          log_cmd[n_log]  = int'(eng_cmd);
          log_byte[n_log] = eng_byte;
        end
        cur_idx = n_log;
        cur_cmd = int'(eng_cmd);
        n_log++;
        cnt = 2;
      end
    end
  end

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 v = reg_rdata;
  endtask

  task automatic push(input int c, input logic [7:0] b, input bit nk, input string t);
    exp_cmd[exp_n] = c; exp_byte[exp_n] = b; exp_nk[exp_n] = nk; exp_tag[exp_n] = t;
    exp_n++;
  endtask

  task automatic push_addr(input logic [9:0] a, input bit ext, input bit rw);
    if (ext) begin
      push(3, {5'b11110, a[9:8], rw}, 1, "R3");
      push(3, a[7:0], 1, "R3");
    end else push(3, {a[6:0], rw}, 1, "R3");
  endtask

  task automatic build(input bit wr, input bit rd, input logic [9:0] a, input bit ext,
                       input int txl, input int rxl, input bit rep,
                       input logic [63:0] tx, input int nk);
    exp_n = 0; exp_err = 0;
    push(1, 8'h00, 0, "R2");
    if (wr) begin
      push_addr(a, ext, 1'b0);
      for (int k = 0; k < txl; k++) push(3, tx[8*k +: 8], 1, "R4");
      if (rd) begin
        if (rep) begin
          push(2, 8'h00, 0, "R6");
          push(3, ext ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, 1, "R3");
        end else begin
          push(6, 8'h00, 0, "R6");
          push(1, 8'h00, 0, "R6");
          push_addr(a, ext, 1'b1);
        end
      end
    end else push_addr(a, ext, 1'b1);
    if (rd) for (int k = 0; k < rxl; k++) push((k == rxl - 1) ? 5 : 4, 8'h00, 0, "R5");
    push(6, 8'h00, 0, "R8");
    if (nk >= 0 && nk < exp_n && exp_nk[nk]) begin
      exp_n = nk + 1;
      push(6, 8'h00, 0, "R7");
      exp_err = 1;
    end
  endtask

  task automatic run_txn(input bit wr, input bit rd, input logic [9:0] a, input bit ext,
                         input int txl, input int rxl, input bit rep,
                         input logic [63:0] tx, input int nk, input bit disturb);
    logic [31:0] cw, v;
    logic [63:0] exp_rx;
    bit got;
    n_log = 0; rd_cnt = 0; nack_at = nk; rx_seed = tx[7:0] ^ 8'hA5;
    wr_reg(5, tx[31:0]);
    wr_reg(6, tx[63:32]);
    cw = {11'd0, rep, 1'b1, 3'(rxl - 1), 3'(txl - 1), ext, a, rd, wr};
    wr_reg(0, cw);
    if (disturb) begin
      repeat (4) @(negedge clk);
      wr_reg(0, 32'd0);
    end
    got = 0;
    for (int t = 0; t < 3000 && !got; t++) begin
      rd_reg(2, v);
      got = v[0];
    end
    chk(got, "R8", "cause bit after run", 64'(got), 64'd1);
    chk(irq == (got & mask_now), "R8", "irq equals cause and mask", 64'(irq), 64'(got & mask_now));
    build(wr, rd, a, ext, txl, rxl, rep, tx, nk);
    chk(n_log == exp_n, "R2", "command count", 64'(n_log), 64'(exp_n));
    for (int i = 0; i < exp_n && i < n_log; i++) begin
      chk(log_cmd[i] == exp_cmd[i], exp_tag[i], "command code", 64'(log_cmd[i]), 64'(exp_cmd[i]));
      if (exp_cmd[i] == 3)
        chk(log_byte[i] == exp_byte[i], exp_tag[i], "command byte", 64'(log_byte[i]), 64'(exp_byte[i]));
    end
    rd_reg(1, v);
    chk(v[0] == exp_err, "R7", "status error bit", 64'(v[0]), 64'(exp_err));
    exp_rx = '0;
    if (rd && !exp_err) for (int k = 0; k < rxl; k++) exp_rx[8*k +: 8] = rx_pat(rx_seed, k);
    rd_reg(7, v);
    chk(v == exp_rx[31:0], "R5", "rx low word", 64'(v), 64'(exp_rx[31:0]));
    rd_reg(8, v);
    chk(v == exp_rx[63:32], "R5", "rx high word", 64'(v), 64'(exp_rx[63:32]));
    if (disturb) begin
      rd_reg(0, v);
      chk(v == cw, "R10", "control word kept during run", 64'(v), 64'(cw));
    end
    wr_reg(2, 32'd0);
    rd_reg(2, v);
    chk(v == 32'd0, "R9", "cause cleared", 64'(v), 64'd0);
    chk(irq == 1'b0, "R9", "irq after clear", 64'(irq), 64'd0);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int it;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int r = 0; r < 9; r++) begin
      rd_reg(r, v);
      chk(v == 32'd0, "R1", "register after reset", 64'(v), 64'd0);
    end
    chk(irq == 1'b0 && eng_valid == 1'b0, "R1", "irq/valid after reset",
        64'({irq, eng_valid}), 64'd0);

    // R9 timing word and mask
    wr_reg(4, 32'h1234_5678);
    #1 chk(eng_pace == 32'h1234_5678, "R9", "timing word on eng_pace", 64'(eng_pace), 64'h12345678);
    wr_reg(4, 32'd0);
    #1 chk(eng_pace == 32'd0, "R9", "timing word reset", 64'(eng_pace), 64'd0);
    wr_reg(3, 32'd1); mask_now = 1'b1;

    // sweep
    it = 0;
    for (int m = 0; m < 3; m++)
      for (int e = 0; e < 2; e++)
        for (int rp = 0; rp < 2; rp++)
          for (int ti = 0; ti < 3; ti++)
            for (int ri = 0; ri < 3; ri++) begin
              int txl, rxl;
              logic [63:0] tx;
              txl = (ti == 0) ? 1 : (ti == 1) ? 3 : 8;
              rxl = (ri == 0) ? 1 : (ri == 1) ? 2 : 8;
              tx = 64'h0123_4567_89AB_CDEF ^ {8{8'(it * 13)}};
              run_txn(m != 1, m != 0, 10'(10'h2A5 ^ (it * 37)), e[0], txl, rxl, rp[0], tx, -1, 1'b0);
              it++;
            end

    // R7 NACK at each address/data position of a combined 10-bit run
    for (int p = 1; p <= 6; p++)
      if (p != 5) run_txn(1'b1, 1'b1, 10'h35C, 1'b1, 2, 2, 1'b1, 64'hFEDC_BA98_7654_3210, p, 1'b0);
    // R7 NACK on 7-bit read-only address
    run_txn(1'b0, 1'b1, 10'h051, 1'b0, 1, 4, 1'b0, 64'h0, 1, 1'b0);

    // R10 control write during run
    run_txn(1'b1, 1'b1, 10'h0C3, 1'b0, 4, 3, 1'b0, 64'h1111_2222_3333_4444, -1, 1'b1);

    // R8 mask off: cause set, irq low
    wr_reg(3, 32'd0); mask_now = 1'b0;
    run_txn(1'b1, 1'b0, 10'h07F, 1'b0, 2, 1, 1'b0, 64'hAA55, -1, 1'b0);
    wr_reg(3, 32'd1); mask_now = 1'b1;

    // R10 run bit without a phase
    n_log = 0;
    wr_reg(0, 32'h0008_0000);
    repeat (20) @(negedge clk);
    chk(n_log == 0, "R10", "no command without phase bits", 64'(n_log), 64'd0);
    rd_reg(2, v);
    chk(v == 32'd0, "R10", "no cause without phase bits", 64'(v), 64'd0);

    // R9 control cleared by writing zero
    wr_reg(0, 32'd0);
    rd_reg(0, v);
    chk(v == 32'd0, "R9", "control cleared", 64'(v), 64'd0);

    summary();
    $finish;
  end
endmodule